// File: doc/BRIEF.md
# Iterative Lowest-Set-Bit Population Counter

This block counts the ones in a wide input word over several clock cycles instead of in one wide combinational step. On an accepted start strobe it copies the data word into a working register. It then removes the lowest set bit of that register once per clock, using the identity x AND (x - 1), and adds one to a running tally on each removal. The run stops when the working register holds no more ones. At that point the tally equals the population count of the word. A run therefore takes a number of cycles that tracks the number of ones in the word.

A threshold is sampled together with the data. When the run finishes, an over-threshold flag is set if the final tally is strictly greater than that threshold. The caller raises `start_i` for one cycle while `busy_o` is low. It then waits for the one-cycle `done_o` pulse and reads `count_o` and `over_o`. Both results hold their values until the next accepted start.

The controller has three states:
- `PC_IDLE`: waiting.
- `PC_RUN`: clearing one bit per cycle.
- `PC_DONE`: one cycle that signals completion.

Its transitions are:
- **accept**: IDLE→RUN or DONE→RUN, taken when start is high.
- **step**: RUN→RUN, taken while the working word is nonzero.
- **finish**: RUN→DONE, taken when the working word is zero.
- **retire**: DONE→IDLE, taken when start is low.
- **reset**: any state→IDLE.

Top module: `popcount_iter`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, forces the unit idle. After that edge `busy_o`, `done_o`, `over_o` are 0 and `count_o` is 0, and they stay there until a start.
- R2: A start seen at a clock edge while `busy_o` is low loads the data and threshold. After that edge `busy_o` is 1, `count_o` is 0 and `over_o` is 0.
- R3: Each cycle in RUN with a nonzero working word clears exactly one bit (the lowest set bit) of the working word and raises `count_o` by exactly one.
- R4: The final `count_o` equals the number of ones in the loaded 256-bit word. An all-ones word gives 256, which fits the 9-bit output without overflow.
- R5: For a word with N ones, `busy_o` is 1 for exactly N+1 cycles after the accepting edge. An all-zeros word therefore finishes one cycle after start with a count of 0.
- R6: `done_o` is high for exactly one cycle. It rises in the same cycle that `busy_o` falls.
- R7: At completion, `over_o` is 1 exactly when the final count is strictly greater than the 9-bit threshold captured at start. Equality gives 0, and a threshold of 256 or more never sets the flag.
- R8: A start raised while `busy_o` is 1 is ignored. The run in progress finishes with the result of the word loaded first.
- R9: While `busy_o` is low and no start arrives, `count_o` and `over_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, accepted only while busy_o is low |
| data_i | input | 256 | Word whose ones are counted |
| thresh_i | input | 9 | Threshold compared with the final count |
| count_o | output | 9 | Running, then final, number of ones |
| over_o | output | 1 | Final count strictly greater than the threshold |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the following corner cases:
- **All-zeros word.** A controller that always takes one step before testing for zero would report a count of 1 or take two cycles.
- **All-ones word.** An undersized tally would wrap to 0.
- **Count equal to the threshold.** A comparison using greater-or-equal would raise the flag here.
- **Thresholds of 256 and 511.** A truncated compare would flag these wrongly.
- **Start mid-run.** A design that accepts it would restart and report the second word's count.
- **Reset mid-run.** A design that resets incompletely would leave busy or the count set.

It also measures the exact busy length for several bit patterns. An off-by-one exit condition shows up as a wrong latency.

// File: rtl/popc_pkg.sv
package popc_pkg;
    typedef enum logic [1:0] {
        PC_IDLE = 2'd0,
        PC_RUN  = 2'd1,
        PC_DONE = 2'd2
    } pc_state_e;
endpackage

// File: rtl/popc_lsb_clear.sv
module popc_lsb_clear #(
    parameter int W     = 256,
    parameter int STYLE = 0
) (
    input  logic [W-1:0] work_i,
    output logic [W-1:0] next_o,
    output logic         zero_o
);
    generate
        if (STYLE == 0) begin : g_sub
            assign next_o = work_i & (work_i - W'(1));
        end else begin : g_iso
            logic [W-1:0] lowest;
            assign lowest = work_i & (~work_i + W'(1));
            assign next_o = work_i ^ lowest;
        end
    endgenerate

    assign zero_o = (work_i == '0);
endmodule

// File: rtl/popc_tally.sv
module popc_tally #(
    parameter int W  = 256,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + CW'(1);
        end
    end

    assign count_o = count_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (inc_i && !clr_i) |-> (count_q < CW'(W))); // R4
endmodule

// File: rtl/popc_ctrl.sv
module popc_ctrl
    import popc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic zero_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o,
    output logic done_o
);
    pc_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            PC_IDLE: begin
                if (start_i) begin
                    load_o  = 1'b1;
                    state_d = PC_RUN;
                end
            end
            PC_RUN: begin
                busy_o = 1'b1;
                if (zero_i) begin
                    finish_o = 1'b1;
                    state_d  = PC_DONE;
                end else begin
                    step_o = 1'b1;
                end
            end
            PC_DONE: begin
                done_o = 1'b1;
                if (start_i) begin
                    load_o  = 1'b1;
                    state_d = PC_RUN;
                end else begin
                    state_d = PC_IDLE;
                end
            end
            default: state_d = PC_IDLE;
        endcase
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PC_DONE) |=> (state_q != PC_DONE)); // R6
    AST_LOAD_NOT_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |-> (state_q != PC_RUN)); // R8
endmodule

// File: rtl/popcount_iter.sv
module popcount_iter #(
    parameter int W     = 256,
    parameter int CW    = $clog2(W + 1),
    parameter int STYLE = 0
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [W-1:0]  data_i,
    input  logic [CW-1:0] thresh_i,
    output logic [CW-1:0] count_o,
    output logic          over_o,
    output logic          busy_o,
    output logic          done_o
);
    logic [W-1:0]  work_q, work_next;
    logic [CW-1:0] thr_q;
    logic          work_zero, load, step, finish, flag_q;

    popc_lsb_clear #(.W(W), .STYLE(STYLE)) u_clear (
        .work_i (work_q),
        .next_o (work_next),
        .zero_o (work_zero)
    );

    popc_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .zero_i   (work_zero),
        .load_o   (load),
        .step_o   (step),
        .finish_o (finish),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    popc_tally #(.W(W), .CW(CW)) u_tally (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (load),
        .inc_i   (step),
        .count_o (count_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            work_q <= '0;
            thr_q  <= '0;
            flag_q <= 1'b0;
        end else if (load) begin
            work_q <= data_i;
            thr_q  <= thresh_i;
            flag_q <= 1'b0;
        end else begin
            if (step) begin
                work_q <= work_next;
            end
            if (finish) begin
                flag_q <= (count_o > thr_q);
            end
        end
    end

    assign over_o = flag_q;

    AST_START_LOADS: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o) |=> (busy_o && count_o == '0 && !over_o)); // R2
    AST_STEP_CLEARS_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !work_zero) |=> ($countones(work_q) + 1 == $countones($past(work_q)))); // R3
    AST_STEP_COUNTS_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !work_zero) |=> (count_o == $past(count_o) + CW'(1))); // R3
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!busy_o && $past(busy_o))); // R6
    AST_FLAG_STRICT: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (over_o == (count_o > thr_q))); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !start_i) |=> ($stable(count_o) && $stable(over_o))); // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !work_zero) |=> busy_o); // R8
endmodule

// File: tb/tb_popcount_iter.sv
module tb_popcount_iter;
    localparam int W  = 256;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [W-1:0]  data;
    logic [CW-1:0] thresh;
    logic [CW-1:0] count;
    logic          over, busy, done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    popcount_iter dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .data_i   (data),
        .thresh_i (thresh),
        .count_o  (count),
        .over_o   (over),
        .busy_o   (busy),
        .done_o   (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(count == '0, "R1 count", int'(count), 0);
        chk(over == 1'b0, "R1 over", int'(over), 0);
    endtask

    task automatic run_word(input logic [W-1:0] d, input int thr, input string tag);
        int n = ones(d);
        int k = 0;
        @(negedge clk);
        data = d; thresh = CW'(thr); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && (count == '0 || n == 0), {"R2 ", tag}, int'(count), 0);
        while (!done && k < 600) begin
            @(negedge clk);
            k++;
        end
        chk(k == n + 1, {"R5 latency ", tag}, k, n + 1);
        chk(int'(count) == n, {"R4 count ", tag}, int'(count), n);
        chk(over == (n > thr), {"R7 flag ", tag}, int'(over), int'(n > thr));
        chk(busy == 1'b0, {"R6 busy low at done ", tag}, int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, {"R6 done pulse ", tag}, int'(done), 0);
        chk(int'(count) == n && over == (n > thr), {"R9 hold ", tag}, int'(count), n);
    endtask

    task automatic busy_start();
        logic [W-1:0] d = '0;
        int k = 0;
        d[3:0] = 4'hF; d[200] = 1'b1; d[255] = 1'b1;
        @(negedge clk);
        data = d; thresh = 9'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        data = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && k < 600) begin
            @(negedge clk);
            k++;
        end
        chk(count == 9'd6, "R8 start while busy ignored", int'(count), 6);
    endtask

    task automatic reset_mid_run();
        @(negedge clk);
        data = '1; thresh = 9'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0 && count == '0 && over == 1'b0, "R1 reset mid-run", int'(count), 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 stays idle", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] p;
        rst = 1'b1; start = 1'b0; data = '0; thresh = '0;
        do_reset();
        run_word('0, 0, "zeros");
        run_word('1, 255, "ones thr255");
        run_word('1, 256, "ones thr256");
        run_word('1, 511, "ones thr511");
        p = '0; p[11:0] = 12'hF0F;
        run_word(p, 8, "equal thr");
        run_word(p, 7, "below thr");
        p = '0; p[255] = 1'b1;
        run_word(p, 0, "top bit");
        p = '0;
        for (int i = 0; i < W; i += 3) p[i] = 1'b1;
        run_word(p, 100, "every third");
        busy_start();
        reset_mid_run();
        run_word({8{32'hA5A5_0F01}}, 60, "mixed");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule